// File: doc/BRIEF.md
# Synthesizer Configuration Word Loader

This block keeps the divider and test-select configuration of a clock synthesizer. The configuration can reach it in two ways. A three-wire serial port sends a 12-bit word into a shift register, and a serial load strobe moves that word into the configuration registers. A set of parallel pins carries a 7-bit feedback divider value and a 2-bit post-divider code, and a separate parallel load strobe takes them in.

Each configuration register behaves like a transparent latch. The serial path is open while its strobe is high and freezes on the falling edge. The parallel path is open while its strobe is low and freezes on the rising edge. If both paths are open at once, the parallel path decides the divider fields. The test-select field comes only from the serial word.

All external strobes and the serial data are sampled in the system clock domain through a short synchronizer. The serial clock is turned into a one-cycle shift pulse on its rising edge. Holding the parallel strobe low through reset and releasing it afterwards loads the parallel pins at power-up.

Top module: `cfg_latch`

## Requirements
- R1: While reset is asserted, the outputs read divider M = all ones (7'h7F), post-divider N = all ones (2'b11) and test select T = 0.
- R2: Each rising edge of serClk shifts serData into bit 0 of a 12-bit register and moves the older bits up by one. The first bit sent ends up in bit 11 after twelve edges. Falling edges of serClk do not shift.
- R3: While serLoad is high and parLoad is high, M takes shift bits [11:5], N takes bits [4:3] and T takes bits [2:0]. A bit shifted in during this time shows up on the outputs.
- R4: While serLoad is low and parLoad is high, M, N and T hold their values, even when new serial bits are shifted in.
- R5: While parLoad is low, M and N follow parM and parN. After parLoad rises, later changes on parM and parN have no effect.
- R6: When parLoad is low and serLoad is high together, M and N come from parM and parN and not from the shift register.
- R7: T is loaded only by the serial path. It keeps its value during and after any parallel load.
- R8: If parLoad is held low through reset and then raised, the outputs hold the parallel values that were present when it rose.
- R9: When more than twelve bits are shifted, only the last twelve bits sent remain in the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes and data |
| rst_n | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial shift clock; shifts on its rising edge |
| serData | input | 1 | Serial data bit, most significant bit first |
| serLoad | input | 1 | Serial load strobe; open while high, freezes on fall |
| parLoad | input | 1 | Parallel load strobe; open while low, freezes on rise |
| parM | input | 7 | Parallel feedback divider value |
| parN | input | 2 | Parallel post-divider code |
| cfgM | output | 7 | Configured feedback divider |
| cfgN | output | 2 | Configured post-divider code |
| cfgT | output | 3 | Configured test-select field |

## Verification
The serial path is tested with distinct 12-bit words whose M, N and T fields all differ, so a swapped or shifted field mapping gives a wrong value. The bench also shifts with the serial strobe open, to show transparency, and with it closed, to show holding. A 15-bit burst shows that only the last twelve bits are kept. The parallel strobe is tested alone, with its inputs changed both while it is open and after it has closed, and together with an open serial strobe. These cases separate the priority order and confirm that T never comes from the pins. A release right after reset checks the power-up capture.

// File: rtl/cfg_latch_pkg.sv
package cfg_latch_pkg;

  // strobes handed from the control to the datapath, one system clock wide
  typedef struct packed {
    logic shiftEn;   // one-cycle pulse on a serial clock rising edge
    logic serBit;    // synchronized serial data bit
    logic serOpen;   // serial latch transparent
    logic parOpen;   // parallel latch transparent
  } strobes_t;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage[s] <= '0;
      end else if (s == 0) begin
        stage[s] <= din;
      end else begin
        stage[s] <= stage[(s == 0) ? 0 : s - 1];
      end
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/cfg_latch_ctrl.sv
module cfg_latch_ctrl
  import cfg_latch_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     serClk,
  input  logic     serData,
  input  logic     serLoad,
  input  logic     parLoad,
  output strobes_t strobes
);

  localparam int NUM_IN = 4;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncIn;
  logic              serClkPrev;

  assign rawIn = {serClk, serData, serLoad, parLoad};

  cfg_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rawIn),
    .dout (syncIn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) serClkPrev <= 1'b0;
    else        serClkPrev <= syncIn[3];
  end

  always_comb begin
    strobes.shiftEn = syncIn[3] & ~serClkPrev;
    strobes.serBit  = syncIn[2];
    strobes.serOpen = syncIn[1];
    strobes.parOpen = ~syncIn[0];
  end

endmodule

// File: rtl/cfg_latch_data.sv
module cfg_latch_data
  import cfg_latch_pkg::*;
#(
  parameter int M_W = 7,
  parameter int N_W = 2,
  parameter int T_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  strobes_t       strobes,
  input  logic [M_W-1:0] parM,
  input  logic [N_W-1:0] parN,
  output logic [M_W-1:0] cfgM,
  output logic [N_W-1:0] cfgN,
  output logic [T_W-1:0] cfgT
);

  localparam int SHIFT_W = M_W + N_W + T_W;
  localparam int N_LO    = T_W;
  localparam int M_LO    = T_W + N_W;

  logic [SHIFT_W-1:0] shiftReg;

  // serial word, oldest bit travels toward the top
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               shiftReg <= '0;
    else if (strobes.shiftEn) shiftReg <= {shiftReg[SHIFT_W-2:0], strobes.serBit};
  end

  // divider fields: parallel path first, serial second
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgM <= '1;
      cfgN <= '1;
    end else if (strobes.parOpen) begin
      cfgM <= parM;
      cfgN <= parN;
    end else if (strobes.serOpen) begin
      cfgM <= shiftReg[M_LO +: M_W];
      cfgN <= shiftReg[N_LO +: N_W];
    end
  end

  // test-select field: serial path only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cfgT <= '0;
    else if (strobes.serOpen) cfgT <= shiftReg[T_W-1:0];
  end

endmodule

// File: rtl/cfg_latch.sv
module cfg_latch
  import cfg_latch_pkg::*;
#(
  parameter int M_W         = 7,
  parameter int N_W         = 2,
  parameter int T_W         = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           serClk,
  input  logic           serData,
  input  logic           serLoad,
  input  logic           parLoad,
  input  logic [M_W-1:0] parM,
  input  logic [N_W-1:0] parN,
  output logic [M_W-1:0] cfgM,
  output logic [N_W-1:0] cfgN,
  output logic [T_W-1:0] cfgT
);

  strobes_t strobes;

  cfg_latch_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .serClk (serClk),
    .serData(serData),
    .serLoad(serLoad),
    .parLoad(parLoad),
    .strobes(strobes)
  );

  cfg_latch_data #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_data (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobes(strobes),
    .parM   (parM),
    .parN   (parN),
    .cfgM   (cfgM),
    .cfgN   (cfgN),
    .cfgT   (cfgT)
  );

endmodule

// File: rtl/cfg_latch_checker.sv
module cfg_latch_checker
  import cfg_latch_pkg::*;
#(
  parameter int M_W = 7,
  parameter int N_W = 2,
  parameter int T_W = 3
) (
  input logic           clk,
  input logic           rst_n,
  input strobes_t       strobes,
  input logic [M_W-1:0] parM,
  input logic [N_W-1:0] parN,
  input logic [M_W-1:0] cfgM,
  input logic [N_W-1:0] cfgN,
  input logic [T_W-1:0] cfgT
);

  p_reset_defaults_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfgM == {M_W{1'b1}} && cfgN == {N_W{1'b1}} && cfgT == '0));

  p_hold_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.serOpen && !strobes.parOpen) |=> ($stable(cfgM) && $stable(cfgN) && $stable(cfgT)));

  // also covers R6: the parallel value wins whatever the serial strobe does
  p_par_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.parOpen |=> (cfgM == $past(parM) && cfgN == $past(parN)));

  p_t_serial_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.serOpen |=> $stable(cfgT));

endmodule

bind cfg_latch cfg_latch_checker #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .strobes(strobes),
  .parM   (parM),
  .parN   (parN),
  .cfgM   (cfgM),
  .cfgN   (cfgN),
  .cfgT   (cfgT)
);

// File: tb/cfg_latch_test.sv
`timescale 1ns/1ps
module cfg_latch_test;

  localparam int SETTLE = 10;

  typedef struct {
    logic [6:0] m;
    logic [1:0] n;
    logic [2:0] t;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n, serClk, serData, serLoad, parLoad;
  logic [6:0] parM;
  logic [1:0] parN;
  logic [6:0] cfgM;
  logic [1:0] cfgN;
  logic [2:0] cfgT;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  item_t expQ[$];
  logic [11:0] model = '0;

  always #10 clk = ~clk;

  cfg_latch uut (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serData(serData),
    .serLoad(serLoad), .parLoad(parLoad), .parM(parM), .parN(parN),
    .cfgM(cfgM), .cfgN(cfgN), .cfgT(cfgT)
  );

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      checks++;
      if (cfgM !== it.m || cfgN !== it.n || cfgT !== it.t) begin
        errors++;
        $display("FAIL %s: got M=%h N=%b T=%b expected M=%h N=%b T=%b",
                 it.tag, cfgM, cfgN, cfgT, it.m, it.n, it.t);
      end
    end
  end

  task automatic waitCycles(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic expectCfg(logic [6:0] m, logic [1:0] n, logic [2:0] t, string tag);
    item_t it;
    it.m = m; it.n = n; it.t = t; it.tag = tag;
    @(posedge clk);
    expQ.push_back(it);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic sendBit(logic b);
    serData = b;
    waitCycles(3);
    serClk = 1'b1;
    waitCycles(4);
    serClk = 1'b0;
    waitCycles(3);
    model = {model[10:0], b};
  endtask

  task automatic sendWord(logic [14:0] w, int len);
    for (int i = len - 1; i >= 0; i--) sendBit(w[i]);
    waitCycles(SETTLE);
  endtask

  initial begin
    #(20ns * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; serClk = 1'b0; serData = 1'b0; serLoad = 1'b0;
    parLoad = 1'b0; parM = 7'h2A; parN = 2'b01;
    waitCycles(3);
    expectCfg(7'h7F, 2'b11, 3'b000, "R1 reset defaults");

    // R8: parallel strobe low through reset, released afterwards
    rst_n = 1'b1;
    waitCycles(SETTLE);
    parLoad = 1'b1;
    waitCycles(SETTLE);
    parM = 7'h11; parN = 2'b10;
    waitCycles(SETTLE);
    expectCfg(7'h2A, 2'b01, 3'b000, "R8 power-up capture");

    // R2/R4: shift a word with the serial strobe closed
    sendWord(15'hB35, 12);
    expectCfg(7'h2A, 2'b01, 3'b000, "R4 hold while shifting");
    serLoad = 1'b1;
    waitCycles(SETTLE);
    expectCfg(model[11:5], model[4:3], model[2:0], "R2 field map word A");
    expectCfg(7'h59, 2'b10, 3'b101, "R3 serial load word A");
    serLoad = 1'b0;
    waitCycles(SETTLE);

    sendWord(15'h6C3, 12);
    expectCfg(7'h59, 2'b10, 3'b101, "R4 hold second word");
    serLoad = 1'b1;
    waitCycles(SETTLE);
    expectCfg(7'h36, 2'b00, 3'b011, "R3 serial load word B");
    sendWord(15'h1, 1);
    expectCfg(7'h6C, 2'b00, 3'b111, "R3 transparent extra bit");
    serLoad = 1'b0;
    waitCycles(SETTLE);
    sendWord(15'h0, 1);
    expectCfg(7'h6C, 2'b00, 3'b111, "R4 hold after strobe fall");

    // R9: fifteen bits, only the last twelve stay
    sendWord(15'h7ABC, 15);
    serLoad = 1'b1;
    waitCycles(SETTLE);
    expectCfg(7'h55, 2'b11, 3'b100, "R9 last twelve bits");
    serLoad = 1'b0;
    waitCycles(SETTLE);

    // R5/R7: parallel path alone
    parM = 7'h33; parN = 2'b00; parLoad = 1'b0;
    waitCycles(SETTLE);
    expectCfg(7'h33, 2'b00, 3'b100, "R5 parallel open");
    parM = 7'h55; parN = 2'b11;
    waitCycles(SETTLE);
    expectCfg(7'h55, 2'b11, 3'b100, "R7 T kept, R5 follows");
    parLoad = 1'b1;
    waitCycles(SETTLE);
    parM = 7'h01; parN = 2'b01;
    waitCycles(SETTLE);
    expectCfg(7'h55, 2'b11, 3'b100, "R5 capture on rise");

    // R6: both strobes open together
    sendWord(15'h5A5, 12);
    parM = 7'h0F; parN = 2'b10;
    parLoad = 1'b0;
    serLoad = 1'b1;
    waitCycles(SETTLE);
    expectCfg(7'h0F, 2'b10, 3'b101, "R6 parallel priority");
    parLoad = 1'b1;
    waitCycles(SETTLE);
    expectCfg(7'h2D, 2'b00, 3'b101, "R3 serial after parallel release");
    serLoad = 1'b0;
    waitCycles(SETTLE);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule